// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers up to fifteen hardware interrupt sources into a sixteen-bit pending register, qualifies them with a per-bit mask and one global enable flag, and presents the highest-priority eligible request to the processor core. The request comes with a level number and a vector address. Each level owns four consecutive words, so the vector is a fixed base plus four times the level.

Software reaches the block through a small command port. Separate commands load the pending register directly, clear chosen pending bits with write-one-to-clear, set or clear the global enable, and load the mask. Loading a one into a pending bit raises a software interrupt. The write-one-to-clear command lets software read the pending register and then clear only the bits it saw, so a request that arrives in between is not lost. When the core acknowledges a request, the chosen pending bit is dropped and the global enable goes low until software sets it again.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After synchronous reset the pending register reads 0x0000, the mask reads 0x0000, the global enable reads 0, and `irq_o` is low.
- R2: While `src_i[i]` is high, pending bit i+1 is set at the next clock edge. `src_i[14]` drives bit 15, the power-fail source and the highest level.
- R3: Command 1 (load pending) writes `wdata_i` into the pending register. Bit 0 is always forced to 0. A one loaded this way raises a software interrupt.
- R4: Command 2 (write-one-to-clear) clears each pending bit whose `wdata_i` bit is 1 and leaves every other bit unchanged.
- R5: If a hardware source sets a bit in the same cycle that a load, a clear or an acknowledge would drop it, the bit ends up set.
- R6: Command 3 sets the global enable and command 4 clears it. Command 5 loads the mask from `wdata_i`. Command 0 does nothing.
- R7: `irq_o` is high exactly when some bit is set in both the pending register and the mask while the global enable is 1. `level_o` is the highest such bit index.
- R8: While `irq_o` is high, `vec_o` equals `VEC_BASE + 4*level_o`.
- R9: `ack_i` high while `irq_o` is high clears pending bit `level_o` and the global enable at the next edge; this clear takes precedence over an enable command in the same cycle. `ack_i` has no effect while `irq_o` is low.
- R10: `rdata_o` is combinational from `rsel_i`: 0 returns pending, 1 returns mask, 2 returns the global enable in bit 0 with zeros above, and 3 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 15 | Hardware request lines; bit i feeds pending bit i+1 |
| cmd_i | input | 3 | Register command: 0 none, 1 load pending, 2 clear pending (write-one), 3 enable, 4 disable, 5 load mask |
| wdata_i | input | 16 | Operand for the command |
| rsel_i | input | 2 | Read select: 0 pending, 1 mask, 2 enable, 3 zero |
| rdata_o | output | 16 | Read data |
| irq_o | output | 1 | Eligible request present |
| level_o | output | 4 | Level of the chosen request |
| vec_o | output | 16 | Vector address of the chosen level |
| ack_i | input | 1 | Core acknowledge of the current request |

## Verification
Two pairs of events can land on one bit in the same cycle. A hardware source can raise a bit that a software load or write-one-to-clear is dropping. A source can also re-assert the very level that the core is acknowledging. The directed part of the bench drives each pair on purpose and then reads the pending register back, expecting the bit to remain set. The random phase drives sparse sources, random commands and random acknowledges together and compares every output each cycle against a bench-side model, so many of these collisions also occur at arbitrary levels.

// File: rtl/vic_pkg.sv
package vic_pkg;

    typedef enum logic [2:0] {
        VC_NOP       = 3'd0,
        VC_PEND_LOAD = 3'd1,
        VC_PEND_W1C  = 3'd2,
        VC_GIE_SET   = 3'd3,
        VC_GIE_CLR   = 3'd4,
        VC_MASK_LOAD = 3'd5
    } vic_cmd_e;

    typedef enum logic [1:0] {
        VR_PEND = 2'd0,
        VR_MASK = 2'd1,
        VR_GIE  = 2'd2,
        VR_NONE = 2'd3
    } vic_rsel_e;

    // four words are reserved per level
    localparam int unsigned WORDS_PER_LEVEL_LOG2 = 2;

endpackage

// File: rtl/vic_pending.sv
module vic_pending
    import vic_pkg::*;
#(
    parameter int NUM_SRC = 15,
    localparam int PEND_W = NUM_SRC + 1,
    localparam int LVL_W  = $clog2(PEND_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_SRC-1:0] src_i,
    input  vic_cmd_e          cmd_i,
    input  logic [PEND_W-1:0] wdata_i,
    input  logic              ack_clr_i,
    input  logic [LVL_W-1:0]  ack_lvl_i,
    output logic [PEND_W-1:0] pend_o
);

    logic [PEND_W-1:0] pend_q;
    logic [PEND_W-1:0] pend_nxt;

    always_comb begin
        pend_nxt = pend_q;
        case (cmd_i)
            VC_PEND_LOAD: pend_nxt = wdata_i;
            VC_PEND_W1C:  pend_nxt = pend_q & ~wdata_i;
            default:      ;
        endcase
        if (ack_clr_i) begin
            pend_nxt[ack_lvl_i] = 1'b0;
        end
        // hardware requests are applied last so they win any collision
        pend_nxt    = pend_nxt | {src_i, 1'b0};
        pend_nxt[0] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
        end else begin
            pend_q <= pend_nxt;
        end
    end

    assign pend_o = pend_q;

    a_r2_src_sets: assert property (@(posedge clk) disable iff (rst)
        (|src_i) |=> ((pend_q[NUM_SRC:1] & $past(src_i)) == $past(src_i)));

    a_r4_w1c_keeps: assert property (@(posedge clk) disable iff (rst)
        (cmd_i == VC_PEND_W1C && !ack_clr_i)
        |=> ((($past(pend_q) & ~$past(wdata_i)) & ~pend_q) == '0));

endmodule

// File: rtl/vic_ctrl.sv
module vic_ctrl
    import vic_pkg::*;
#(
    parameter int PEND_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  vic_cmd_e          cmd_i,
    input  logic [PEND_W-1:0] wdata_i,
    input  logic              ack_clr_i,
    output logic [PEND_W-1:0] mask_o,
    output logic              gie_o
);

    logic [PEND_W-1:0] mask_q;
    logic              gie_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            gie_q  <= 1'b0;
        end else begin
            if (cmd_i == VC_MASK_LOAD) begin
                mask_q <= wdata_i;
            end
            if (ack_clr_i) begin
                gie_q <= 1'b0;
            end else if (cmd_i == VC_GIE_SET) begin
                gie_q <= 1'b1;
            end else if (cmd_i == VC_GIE_CLR) begin
                gie_q <= 1'b0;
            end
        end
    end

    assign mask_o = mask_q;
    assign gie_o  = gie_q;

endmodule

// File: rtl/vic_select.sv
module vic_select #(
    parameter int PEND_W = 16,
    localparam int LVL_W = $clog2(PEND_W)
) (
    input  logic [PEND_W-1:0] pend_i,
    input  logic [PEND_W-1:0] mask_i,
    input  logic              gie_i,
    output logic [PEND_W-1:0] elig_o,
    output logic              hit_o,
    output logic [LVL_W-1:0]  lvl_o
);

    genvar g;
    generate
        for (g = 0; g < PEND_W; g++) begin : g_elig
            assign elig_o[g] = pend_i[g] & mask_i[g] & gie_i;
        end
    endgenerate

    // ascending scan: the last (highest) eligible index wins
    always_comb begin
        lvl_o = '0;
        for (int i = 0; i < PEND_W; i++) begin
            if (elig_o[i]) begin
                lvl_o = LVL_W'(i);
            end
        end
    end

    assign hit_o = |elig_o;

endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
    import vic_pkg::*;
#(
    parameter int              NUM_SRC  = 15,
    parameter int              VEC_W    = 16,
    parameter logic [VEC_W-1:0] VEC_BASE = 16'h0040,
    localparam int PEND_W = NUM_SRC + 1,
    localparam int LVL_W  = $clog2(PEND_W)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [2:0]         cmd_i,
    input  logic [PEND_W-1:0]  wdata_i,
    input  logic [1:0]         rsel_i,
    output logic [PEND_W-1:0]  rdata_o,
    output logic               irq_o,
    output logic [LVL_W-1:0]   level_o,
    output logic [VEC_W-1:0]   vec_o,
    input  logic               ack_i
);

    vic_cmd_e          cmd;
    vic_rsel_e         rsel;
    logic [PEND_W-1:0] pend;
    logic [PEND_W-1:0] mask;
    logic [PEND_W-1:0] elig;
    logic              gie;
    logic              hit;
    logic [LVL_W-1:0]  lvl;
    logic              ack_fire;

    assign cmd      = vic_cmd_e'(cmd_i);
    assign rsel     = vic_rsel_e'(rsel_i);
    assign ack_fire = ack_i & hit;

    vic_pending #(.NUM_SRC(NUM_SRC)) u_pend (
        .clk       (clk),
        .rst       (rst),
        .src_i     (src_i),
        .cmd_i     (cmd),
        .wdata_i   (wdata_i),
        .ack_clr_i (ack_fire),
        .ack_lvl_i (lvl),
        .pend_o    (pend)
    );

    vic_ctrl #(.PEND_W(PEND_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cmd_i     (cmd),
        .wdata_i   (wdata_i),
        .ack_clr_i (ack_fire),
        .mask_o    (mask),
        .gie_o     (gie)
    );

    vic_select #(.PEND_W(PEND_W)) u_sel (
        .pend_i (pend),
        .mask_i (mask),
        .gie_i  (gie),
        .elig_o (elig),
        .hit_o  (hit),
        .lvl_o  (lvl)
    );

    always_comb begin
        case (rsel)
            VR_PEND: rdata_o = pend;
            VR_MASK: rdata_o = mask;
            VR_GIE:  rdata_o = {{(PEND_W-1){1'b0}}, gie};
            default: rdata_o = '0;
        endcase
    end

    assign irq_o   = hit;
    assign level_o = lvl;
    assign vec_o   = VEC_BASE + (VEC_W'(lvl) << WORDS_PER_LEVEL_LOG2);

    a_r7_highest: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> ((elig >> level_o) == PEND_W'(1)));

    a_r7_needs_gie: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (gie && ((pend & mask) != '0)));

    a_r9_ack_drops_gie: assert property (@(posedge clk) disable iff (rst)
        (ack_i && irq_o) |=> !gie);

endmodule

// File: tb/vec_irq_ctrl_test.sv
`timescale 1ns/1ps
module vec_irq_ctrl_test;

    localparam logic [15:0] VB = 16'h0040;

    logic        clk = 1'b0;
    logic        rst;
    logic [14:0] src;
    logic [2:0]  cmd;
    logic [15:0] wdata;
    logic [1:0]  rsel;
    logic [15:0] rdata;
    logic        irq;
    logic [3:0]  level;
    logic [15:0] vec;
    logic        ack;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [15:0] m_pend;
    logic [15:0] m_mask;
    logic        m_gie;

    always #2 clk = ~clk;

    vec_irq_ctrl uut (
        .clk(clk), .rst(rst), .src_i(src), .cmd_i(cmd), .wdata_i(wdata),
        .rsel_i(rsel), .rdata_o(rdata), .irq_o(irq), .level_o(level),
        .vec_o(vec), .ack_i(ack)
    );

    function automatic int f_top(input logic [15:0] e);
        for (int i = 15; i >= 0; i--) begin
            if (e[i]) return i;
        end
        return 0;
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic step(input logic [14:0] s, input logic [2:0] c,
                        input logic [15:0] w, input logic [1:0] rs, input logic a);
        logic [15:0] e;
        logic [15:0] np;
        logic        fire;
        int          lv;
        @(negedge clk);
        src = s; cmd = c; wdata = w; rsel = rs; ack = a;
        #1;
        e  = m_pend & m_mask & {16{m_gie}};
        lv = f_top(e);
        chk("R7 irq", {31'b0, irq}, {31'b0, |e});
        if (|e) begin
            chk("R7 level", {28'b0, level}, lv);
            chk("R8 vector", {16'b0, vec}, {16'b0, VB + 16'(lv * 4)});
        end
        case (rs)
            2'd0: chk("R10 read pending", {16'b0, rdata}, {16'b0, m_pend});
            2'd1: chk("R10 read mask", {16'b0, rdata}, {16'b0, m_mask});
            2'd2: chk("R10 read enable", {16'b0, rdata}, {31'b0, m_gie});
            default: chk("R10 read zero", {16'b0, rdata}, 32'b0);
        endcase
        fire = a && (|e);
        np = m_pend;
        if (c == 3'd1) np = w;
        else if (c == 3'd2) np = np & ~w;
        if (fire) np[lv] = 1'b0;
        np    = np | {s, 1'b0};
        np[0] = 1'b0;
        if (c == 3'd5) m_mask = w;
        if (fire) m_gie = 1'b0;
        else if (c == 3'd3) m_gie = 1'b1;
        else if (c == 3'd4) m_gie = 1'b0;
        m_pend = np;
    endtask

    task automatic peek(input string tag, input logic [1:0] rs, input logic [15:0] exp);
        @(negedge clk);
        src = '0; cmd = '0; wdata = '0; ack = 1'b0; rsel = rs;
        #1;
        chk(tag, {16'b0, rdata}, {16'b0, exp});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual running expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1a2b));
        rst = 1'b1; src = '0; cmd = '0; wdata = '0; rsel = '0; ack = 1'b0;
        m_pend = '0; m_mask = '0; m_gie = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1 reset state
        peek("R1 pending after reset", 2'd0, 16'h0000);
        chk("R1 irq after reset", {31'b0, irq}, 32'd0);
        peek("R1 mask after reset", 2'd1, 16'h0000);
        peek("R1 enable after reset", 2'd2, 16'h0000);

        // R6 mask and enable commands
        step('0, 3'd5, 16'hFFFF, 2'd0, 1'b0);
        step('0, 3'd3, 16'h0000, 2'd0, 1'b0);
        peek("R6 enable set", 2'd2, 16'h0001);
        peek("R6 mask loaded", 2'd1, 16'hFFFF);

        // R3 software interrupt via load, bit 0 forced low
        step('0, 3'd1, 16'h0201, 2'd0, 1'b0);
        peek("R3 loaded pending", 2'd0, 16'h0200);
        chk("R3 software irq", {31'b0, irq}, 32'd1);
        chk("R3 software level", {28'b0, level}, 32'd9);

        // R9 acknowledge
        step('0, 3'd0, 16'h0000, 2'd0, 1'b1);
        peek("R9 ack clears pending bit", 2'd0, 16'h0000);
        peek("R9 ack clears enable", 2'd2, 16'h0000);

        // R2 hardware sources, incl. power-fail on bit 15
        step(15'h4001, 3'd0, 16'h0000, 2'd0, 1'b0);
        peek("R2 sources set pending", 2'd0, 16'h8002);

        // R4 write-one-to-clear
        step('0, 3'd2, 16'h8000, 2'd0, 1'b0);
        peek("R4 clear only chosen bit", 2'd0, 16'h0002);

        // R5 hardware set vs clear / load
        step(15'h0001, 3'd2, 16'h0002, 2'd0, 1'b0);
        peek("R5 set beats clear", 2'd0, 16'h0002);
        step(15'h0008, 3'd1, 16'h0000, 2'd0, 1'b0);
        peek("R5 set beats load", 2'd0, 16'h0010);

        // R7 / R8 priority among coincident requests
        step('0, 3'd1, 16'h0C30, 2'd0, 1'b0);
        step('0, 3'd3, 16'h0000, 2'd0, 1'b0);
        peek("R7 pending for priority", 2'd0, 16'h0C30);
        chk("R7 highest level", {28'b0, level}, 32'd11);
        chk("R8 vector of level 11", {16'b0, vec}, {16'b0, VB + 16'd44});
        step('0, 3'd5, 16'hF7FF, 2'd0, 1'b0);
        peek("R7 mask applied", 2'd1, 16'hF7FF);
        chk("R7 masked level", {28'b0, level}, 32'd10);
        step('0, 3'd4, 16'h0000, 2'd0, 1'b0);
        peek("R7 disabled", 2'd2, 16'h0000);
        chk("R7 no irq when disabled", {31'b0, irq}, 32'd0);

        // R9 ack with no request
        step('0, 3'd0, 16'h0000, 2'd0, 1'b1);
        peek("R9 idle ack ignored", 2'd0, 16'h0C30);

        // R5 source re-asserts the acknowledged level
        step('0, 3'd3, 16'h0000, 2'd0, 1'b0);
        step(15'h0200, 3'd0, 16'h0000, 2'd0, 1'b1);
        peek("R5 set beats ack", 2'd0, 16'h0C30);
        peek("R9 ack drops enable", 2'd2, 16'h0000);

        // R10 zero select
        peek("R10 select 3 reads zero", 2'd3, 16'h0000);

        // random phase
        for (int n = 0; n < 600; n++) begin
            logic [14:0] s;
            logic [2:0]  c;
            s = (($urandom % 6) == 0) ? (15'($urandom) & 15'($urandom) & 15'($urandom)) : 15'd0;
            c = 3'($urandom % 8);
            step(s, c, 16'($urandom), 2'($urandom), 1'($urandom));
        end
        step('0, 3'd0, 16'h0000, 2'd0, 1'b0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule